// File: doc/BRIEF.md
# Grouped GPIO External Interrupt Controller

This block gathers interrupt requests from up to fifteen groups of sixteen GPIO lines each (nine groups by default). Every line passes through a two-stage synchroniser and then an edge or level detector. A detected event sets a per-line pending bit. Software programs the detection type, blocks or enables lines through a mask, and retires events by writing ones to the pending words. All of this happens over a simple single-cycle word-addressed register bus.

A single combined interrupt output tells the CPU that at least one pending line is not masked. A read-only service word names the line to handle next. Its upper nibble is the group index plus one, and its lower nibble is the line within that group. An upper nibble of zero means there is nothing to do. The interrupt handler reads the service word, handles the named line, clears its pending bit, and repeats until the service word reads idle. Group index 0 (reported as group 1) can hold two eight-line banks: lines 0 to 7 belong to one bank and lines 8 to 15 to the other.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset every configuration field is 0, every mask bit is 1, every pending bit is 0, `irq_o` is low and the service word reads 0.
- R2: A 4-bit trigger code selects the detection type. 0 is low level, 1 is high level, 2 is falling edge, 4 is rising edge and 6 is both edges. Any other code never sets a pending bit.
- R3: Lines 4k to 4k+3 of a group share one trigger field. That field sits at bits 4k+3:4k of the group's 16-bit half of its configuration word.
- R4: Bus word addresses are: configuration 0x00+w, mask 0x08+w and pending 0x10+w, for w = g/2. The service word is at 0x18. Even groups use bits 15:0 of a word and odd groups use bits 31:16. Halves with no group behind them read 0.
- R5: A mask bit of 1 keeps its line out of `irq_o` and out of the service word, and a 0 lets it through. A masked line still records pending events.
- R6: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If a new event arrives in the same cycle as the clear, the event wins.
- R7: A level-type line whose level is still active sets its pending bit again immediately after it is cleared.
- R8: `irq_o` is high exactly while some pending bit has its mask bit at 0.
- R9: The service word carries the group index plus one in bits 7:4 and the line number in bits 3:0. It reads 0 when no unmasked line is pending.
- R10: The service word names the lowest-indexed group with an unmasked pending line. Within that group it names the lowest-numbered such line.
- R11: A pin change made between two clock edges becomes visible in the pending bit, and in `irq_o` for an unmasked line, right after the third following rising edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | GROUPS*16 | Asynchronous GPIO levels, group g at bits 16g+15:16g |
| bus_wr_i | input | 1 | Write strobe for the current bus word |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is the collision between a clear write and a fresh event on the same line in the same cycle. The bench creates it with a high-level line whose pin stays asserted. The clear write then always meets an active detector, so the pending bit must read back as 1 straight after the write.

Priority ordering is reached by raising several lines in different groups at the same time. The bench then retires them one by one and checks that the service word walks through them in group-then-line order.

Trigger decoding is checked on a single line. For each code, the bench sets an idle pin level, clears the pending bit, confirms it stays clear, and only then applies the transition under test.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;

    localparam int LINES       = 16;
    localparam int SEL_W       = 4;
    localparam int SEL_PER_GRP = LINES / SEL_W;
    localparam int WORD_W      = 32;
    localparam int ADDR_W      = 6;
    localparam int WORD_IDX_W  = 3;

    typedef enum logic [1:0] {
        RG_CFG = 2'd0,
        RG_MSK = 2'd1,
        RG_PND = 2'd2,
        RG_SVC = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        TK_NONE,
        TK_LOW,
        TK_HIGH,
        TK_FALL,
        TK_RISE,
        TK_BOTH
    } trig_kind_e;

    typedef struct packed {
        logic [3:0] grp;
        logic [3:0] pin;
    } svc_t;

    typedef struct packed {
        logic                  in_map;
        region_e               region;
        logic [WORD_IDX_W-1:0] word;
    } bus_dec_t;

    function automatic trig_kind_e decode_trig(input logic [SEL_W-1:0] code);
        case (code)
            4'd0:    return TK_LOW;
            4'd1:    return TK_HIGH;
            4'd2:    return TK_FALL;
            4'd4:    return TK_RISE;
            4'd6:    return TK_BOTH;
            default: return TK_NONE;
        endcase
    endfunction

    function automatic logic line_hit(input trig_kind_e k, input logic now, input logic prev);
        case (k)
            TK_LOW:  return ~now;
            TK_HIGH: return now;
            TK_FALL: return prev & ~now;
            TK_RISE: return now & ~prev;
            TK_BOTH: return now ^ prev;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bus_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        bus_dec_t d;
        d.in_map = ~a[5];
        d.region = region_e'(a[4:3]);
        d.word   = a[2:0];
        return d;
    endfunction

endpackage

// File: rtl/grp_irq_detect.sv
module grp_irq_detect
    import grp_irq_pkg::*;
#(
    parameter int GROUPS = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [GROUPS*LINES-1:0]  pins_i,
    input  logic [GROUPS*LINES-1:0]  cfg_i,
    output logic [GROUPS*LINES-1:0]  hit_o
);

    localparam int N = GROUPS * LINES;

    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pins_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar l = 0; l < LINES; l++) begin : g_line
            localparam int IDX = g * LINES + l;
            localparam int FLD = g * LINES + SEL_W * (l / SEL_W);
            trig_kind_e kind;
            assign kind       = decode_trig(cfg_i[FLD +: SEL_W]);
            assign hit_o[IDX] = line_hit(kind, sync_q[IDX], prev_q[IDX]);
        end
    end

endmodule

// File: rtl/grp_irq_regs.sv
module grp_irq_regs
    import grp_irq_pkg::*;
#(
    parameter int GROUPS = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [WORD_W-1:0]        wdata_i,
    input  logic [GROUPS*LINES-1:0]  hit_i,
    input  svc_t                     svc_i,
    output logic [WORD_W-1:0]        rdata_o,
    output logic [GROUPS*LINES-1:0]  cfg_o,
    output logic [GROUPS*LINES-1:0]  mask_o,
    output logic [GROUPS*LINES-1:0]  pend_o
);

    localparam int N = GROUPS * LINES;

    bus_dec_t     dec;
    logic [N-1:0] cfg_q;
    logic [N-1:0] mask_q;
    logic [N-1:0] pend_q;
    logic         pend_wr_any;

    assign dec         = decode_addr(addr_i);
    assign pend_wr_any = wr_i && dec.in_map && (dec.region == RG_PND);

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        localparam int W = g / 2;
        localparam int H = g % 2;
        logic             hit_word;
        logic [LINES-1:0] clr;

        assign hit_word = wr_i && dec.in_map && (dec.word == WORD_IDX_W'(W));
        assign clr      = (hit_word && dec.region == RG_PND) ? wdata_i[H*LINES +: LINES] : '0;

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g*LINES +: LINES]  <= '0;
                mask_q[g*LINES +: LINES] <= '1;
                pend_q[g*LINES +: LINES] <= '0;
            end else begin
                if (hit_word && dec.region == RG_CFG)
                    cfg_q[g*LINES +: LINES] <= wdata_i[H*LINES +: LINES];
                if (hit_word && dec.region == RG_MSK)
                    mask_q[g*LINES +: LINES] <= wdata_i[H*LINES +: LINES];
                pend_q[g*LINES +: LINES] <= (pend_q[g*LINES +: LINES] & ~clr)
                                          | hit_i[g*LINES +: LINES];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (dec.in_map) begin
            case (dec.region)
                RG_CFG: begin
                    for (int g = 0; g < GROUPS; g++)
                        if (dec.word == WORD_IDX_W'(g / 2))
                            rdata_o[(g % 2)*LINES +: LINES] = cfg_q[g*LINES +: LINES];
                end
                RG_MSK: begin
                    for (int g = 0; g < GROUPS; g++)
                        if (dec.word == WORD_IDX_W'(g / 2))
                            rdata_o[(g % 2)*LINES +: LINES] = mask_q[g*LINES +: LINES];
                end
                RG_PND: begin
                    for (int g = 0; g < GROUPS; g++)
                        if (dec.word == WORD_IDX_W'(g / 2))
                            rdata_o[(g % 2)*LINES +: LINES] = pend_q[g*LINES +: LINES];
                end
                default: begin
                    if (dec.word == '0)
                        rdata_o = {{(WORD_W-8){1'b0}}, svc_i};
                end
            endcase
        end
    end

    assign cfg_o  = cfg_q;
    assign mask_o = mask_q;
    assign pend_o = pend_q;

    // A detector hit in one cycle is always present in the pending bits on the next.
    AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pend_q & $past(hit_i)) == $past(hit_i))); // R6

    // Pending bits only fall in the cycle after a clear write.
    AST_PEND_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(pend_wr_any)) |-> (($past(pend_q) & ~pend_q) == '0)); // R6

endmodule

// File: rtl/grp_irq_service.sv
module grp_irq_service
    import grp_irq_pkg::*;
#(
    parameter int GROUPS = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [GROUPS*LINES-1:0]  pend_i,
    input  logic [GROUPS*LINES-1:0]  mask_i,
    output svc_t                     svc_o,
    output logic                     any_o
);

    localparam int N = GROUPS * LINES;

    logic [N-1:0] active;
    logic         found;

    assign active = pend_i & ~mask_i;
    assign any_o  = |active;

    always_comb begin
        found     = 1'b0;
        svc_o.grp = '0;
        svc_o.pin = '0;
        for (int g = 0; g < GROUPS; g++) begin
            for (int l = 0; l < LINES; l++) begin
                if (!found && active[g*LINES + l]) begin
                    found     = 1'b1;
                    svc_o.grp = 4'(g + 1);
                    svc_o.pin = 4'(l);
                end
            end
        end
    end

    logic [7:0]   sel_idx;
    logic [N-1:0] below;
    assign sel_idx = {svc_o.grp - 4'd1, svc_o.pin};
    assign below   = (N'(1) << sel_idx) - N'(1);

    AST_SVC_IDLE: assert property (@(posedge clk) disable iff (rst)
        (svc_o.grp == 4'd0) == !any_o); // R9

    AST_SVC_NAMES_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        any_o |-> active[sel_idx]); // R9

    AST_SVC_LOWEST: assert property (@(posedge clk) disable iff (rst)
        any_o |-> ((active & below) == '0)); // R10

endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
    import grp_irq_pkg::*;
#(
    parameter int GROUPS = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [GROUPS*16-1:0]     pins_i,
    input  logic                     bus_wr_i,
    input  logic [5:0]               bus_addr_i,
    input  logic [31:0]              bus_wdata_i,
    output logic [31:0]              bus_rdata_o,
    output logic                     irq_o
);

    localparam int N = GROUPS * LINES;

    logic [N-1:0] hit;
    logic [N-1:0] cfg;
    logic [N-1:0] mask;
    logic [N-1:0] pend;
    svc_t         svc;
    logic         any;

    grp_irq_detect #(.GROUPS(GROUPS)) u_detect (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins_i),
        .cfg_i  (cfg),
        .hit_o  (hit)
    );

    grp_irq_regs #(.GROUPS(GROUPS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .hit_i   (hit),
        .svc_i   (svc),
        .rdata_o (bus_rdata_o),
        .cfg_o   (cfg),
        .mask_o  (mask),
        .pend_o  (pend)
    );

    grp_irq_service #(.GROUPS(GROUPS)) u_service (
        .clk    (clk),
        .rst    (rst),
        .pend_i (pend),
        .mask_i (mask),
        .svc_o  (svc),
        .any_o  (any)
    );

    assign irq_o = any;

    AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (svc.grp != 4'd0)); // R8

endmodule

// File: tb/grp_irq_ctrl_tb.sv
module grp_irq_ctrl_tb;

    localparam int GROUPS = 9;
    localparam int NP     = GROUPS * 16;
    localparam logic [5:0] CFG = 6'h00;
    localparam logic [5:0] MSK = 6'h08;
    localparam logic [5:0] PND = 6'h10;
    localparam logic [5:0] SVC = 6'h18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pins = '0;
    logic          wr = 1'b0;
    logic [5:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    grp_irq_ctrl #(.GROUPS(GROUPS)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .pins_i      (pins),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic br(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clean();
        for (int w = 0; w < 5; w++) bw(CFG + 6'(w), 32'h3333_3333);
        for (int w = 0; w < 5; w++) bw(MSK + 6'(w), 32'hFFFF_FFFF);
        settle(2);
        for (int w = 0; w < 5; w++) bw(PND + 6'(w), 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        br(CFG + 6'd0, d); chk("R1 cfg word0", d, 32'h0);
        br(MSK + 6'd0, d); chk("R1 mask word0", d, 32'hFFFF_FFFF);
        br(PND + 6'd2, d); chk("R1 pend word2", d, 32'h0);
        br(SVC, d);        chk("R1 service", d, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic run_trig(input logic [3:0] code, input logic v0, input logic v1, input logic exp);
        logic [31:0] d;
        pins[32] = v0;
        settle(4);
        bw(CFG + 6'd1, {28'h3333333, code});
        bw(PND + 6'd1, 32'hFFFF_FFFF);
        settle(3);
        br(PND + 6'd1, d);
        chk($sformatf("R2 code %0d idle", code), {31'b0, d[0]}, 32'h0);
        pins[32] = v1;
        settle(3);
        br(PND + 6'd1, d);
        chk($sformatf("R2 code %0d %0b->%0b", code, v0, v1), {31'b0, d[0]}, {31'b0, exp});
    endtask

    task automatic t_encodings();
        clean();
        run_trig(4'd0, 1'b1, 1'b0, 1'b1);
        run_trig(4'd1, 1'b0, 1'b1, 1'b1);
        run_trig(4'd2, 1'b1, 1'b0, 1'b1);
        run_trig(4'd2, 1'b0, 1'b1, 1'b0);
        run_trig(4'd4, 1'b0, 1'b1, 1'b1);
        run_trig(4'd4, 1'b1, 1'b0, 1'b0);
        run_trig(4'd6, 1'b0, 1'b1, 1'b1);
        run_trig(4'd6, 1'b1, 1'b0, 1'b1);
        run_trig(4'd5, 1'b0, 1'b1, 1'b0);
        run_trig(4'd5, 1'b1, 1'b0, 1'b0);
        run_trig(4'd7, 1'b0, 1'b1, 1'b0);
        run_trig(4'd8, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_shared();
        logic [31:0] d;
        clean();
        bw(CFG + 6'd1, 32'h3343_3333);
        for (int l = 4; l <= 8; l++) pins[48 + l] = 1'b1;
        settle(3);
        br(PND + 6'd1, d);
        chk("R3 field 1 of odd group covers lines 4..7 only", d, 32'h00F0_0000);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        clean();
        bw(CFG + 6'd4, 32'h3333_3343);
        br(CFG + 6'd4, d); chk("R4 cfg word4 upper half empty", d, 32'h0000_3343);
        br(MSK + 6'd4, d); chk("R4 mask word4 upper half empty", d, 32'h0000_FFFF);
        pins[133] = 1'b1;
        settle(3);
        br(PND + 6'd4, d); chk("R4 group 8 line 5 pending", d, 32'h0000_0020);
        bw(MSK + 6'd4, 32'hFFFF_FFDF);
        br(SVC, d); chk("R9 service group 8 line 5", d, 32'h95);
        chk("R8 irq unmasked", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        clean();
        bw(CFG + 6'd0, 32'h3333_3334);
        pins[3] = 1'b1;
        settle(3);
        br(PND + 6'd0, d); chk("R5 masked line still pends", d, 32'h8);
        chk("R5 masked irq low", {31'b0, irq}, 32'h0);
        br(SVC, d); chk("R5 masked service idle", d, 32'h0);
        bw(MSK + 6'd0, 32'hFFFF_FFF7);
        chk("R8 unmask raises irq", {31'b0, irq}, 32'h1);
        br(SVC, d); chk("R9 service group index 0 line 3", d, 32'h13);
        bw(MSK + 6'd0, 32'hFFFF_FFFF);
        chk("R5 remask drops irq", {31'b0, irq}, 32'h0);
        bw(PND + 6'd0, 32'h8);
        br(PND + 6'd0, d); chk("R6 clear line 3", d, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        clean();
        bw(CFG + 6'd0, 32'h4444_3333);
        pins[18] = 1'b1;
        pins[25] = 1'b1;
        settle(3);
        br(PND + 6'd0, d); chk("R6 two pending", d, 32'h0204_0000);
        bw(PND + 6'd0, 32'h0004_0000);
        br(PND + 6'd0, d); chk("R6 write one clears only its bit", d, 32'h0200_0000);
        bw(PND + 6'd0, 32'h0);
        br(PND + 6'd0, d); chk("R6 write zero keeps", d, 32'h0200_0000);
    endtask

    task automatic t_level();
        logic [31:0] d;
        clean();
        bw(CFG + 6'd2, 32'h3331_3333);
        pins[80] = 1'b1;
        settle(3);
        br(PND + 6'd2, d); chk("R7 high level pends", d, 32'h0001_0000);
        bw(PND + 6'd2, 32'h0001_0000);
        br(PND + 6'd2, d); chk("R7 R6 event beats clear while level held", d, 32'h0001_0000);
        pins[80] = 1'b0;
        settle(3);
        br(PND + 6'd2, d); chk("R7 pending latched after level drops", d, 32'h0001_0000);
        bw(PND + 6'd2, 32'h0001_0000);
        br(PND + 6'd2, d); chk("R7 clear sticks once level gone", d, 32'h0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        clean();
        for (int w = 0; w < 5; w++) bw(CFG + 6'(w), 32'h4444_4444);
        for (int w = 0; w < 5; w++) bw(MSK + 6'(w), 32'h0);
        for (int w = 0; w < 5; w++) bw(PND + 6'(w), 32'hFFFF_FFFF);
        br(SVC, d); chk("R9 idle before events", d, 32'h0);
        pins[76]  = 1'b1;
        pins[10]  = 1'b1;
        pins[9]   = 1'b1;
        pins[112] = 1'b1;
        settle(3);
        br(SVC, d); chk("R10 lowest line of lowest group", d, 32'h19);
        bw(PND + 6'd0, 32'h0000_0200);
        br(SVC, d); chk("R10 next line same group", d, 32'h1A);
        bw(PND + 6'd0, 32'h0000_0400);
        br(SVC, d); chk("R10 group 4 line 12", d, 32'h5C);
        bw(PND + 6'd2, 32'h0000_1000);
        br(SVC, d); chk("R10 group 7 line 0", d, 32'h80);
        bw(PND + 6'd3, 32'h0001_0000);
        br(SVC, d); chk("R9 idle after all retired", d, 32'h0);
        chk("R8 irq low when none pending", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_latency();
        logic [31:0] d;
        clean();
        bw(CFG + 6'd3, 32'h3333_3334);
        bw(MSK + 6'd3, 32'hFFFF_FFFD);
        addr = PND + 6'd3;
        pins[97] = 1'b1;
        @(negedge clk);
        br(PND + 6'd3, d); chk("R11 not after one edge", d, 32'h0);
        @(negedge clk);
        br(PND + 6'd3, d); chk("R11 not after two edges", d, 32'h0);
        chk("R11 irq not after two edges", {31'b0, irq}, 32'h0);
        @(negedge clk);
        br(PND + 6'd3, d); chk("R11 set after three edges", d, 32'h2);
        chk("R11 irq after three edges", {31'b0, irq}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        settle(2);
        t_encodings();
        t_shared();
        t_layout();
        t_mask();
        t_w1c();
        t_level();
        t_priority();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule